// File: doc/BRIEF.md
# Supervisor Trap and CSR Unit

This block keeps the supervisor-level trap state of a small RISC-V style core and applies every change to it in one cycle. Six registers are mapped at their usual addresses: status, interrupt enable, trap vector, exception PC, cause and trap value. The pipeline presents at most one CSR instruction per cycle. It gets the old value back on the same cycle, and the new value is in place after the next clock edge.

Three kinds of event redirect the fetch stream. A synchronous exception reported by the pipeline is one. A pending and enabled interrupt line (external, software or timer) is another. The third is a supervisor return. On trap entry the block records the cause, the return PC and the trap value in the same cycle. It also pushes the privilege level and the interrupt enable onto their one-deep stacks and points the fetch stream at the vector. A return pops both stacks and sends fetch to the saved PC.

Every input is sampled on each cycle and accepted at once. There is no back-pressure. The redirect outputs are combinational and valid only in the cycle of the event, so the pipeline must flush on that same cycle.

Top module: `s_trap_csr`

## Requirements
- R1: After reset the mode is supervisor, all six registers read zero, and no redirect is signalled.
- R2: `csr_op` encodes read-write as 1, read-set as 2 and read-clear as 3. Values 5, 6 and 7 are the same three operations using the zero-extended 5-bit `csr_imm` in place of `csr_src`. Values 0 and 4 only read. `csr_rdata` returns the old value in the same cycle and the write lands at the next edge. The addresses are: status 0x100, enable 0x104, vector 0x105, exception PC 0x141, cause 0x142, trap value 0x143. Any other address reads zero and drops writes.
- R3: Only these bits are writable. In status: SIE at bit 1, SPIE at bit 5, SPP at bit 8. In enable: software at bit 1, timer at bit 5, external at bit 9. In the vector, bits 1:0 always read zero.
- R4: A CSR access in user mode does not complete. Instead it traps with cause 2 (illegal instruction), exception PC = `inst_pc` and trap value 0, and it leaves the enable and vector registers unchanged.
- R5: When `exc_valid` is high, a trap is taken with cause = `exc_code` and MSB 0, exception PC = `inst_pc`, and trap value = `exc_tval`.
- R6: A taken interrupt writes a cause with MSB 1 and code 9 (external), 1 (software) or 5 (timer). The exception PC becomes `next_pc` and the trap value becomes 0.
- R7: When more than one interrupt is eligible, external wins over software and software wins over timer.
- R8: An interrupt is eligible only if its enable bit is set and either SIE is 1 or the mode is user. Otherwise nothing happens.
- R9: An exception in the same cycle as an eligible interrupt is taken, and the interrupt is not.
- R10: On trap entry SPP gets the old mode, the mode becomes supervisor (`priv_mode` 1), SPIE gets the old SIE and SIE is cleared. `redirect_pc` is the vector register.
- R11: A return in supervisor mode drives `redirect_pc` = exception PC. The mode then gets SPP, SIE gets SPIE, SPIE becomes 1 and SPP becomes user (0).
- R12: A return attempted in user mode traps as an illegal instruction (cause 2).
- R13: Event precedence is trap, then return, then CSR write. A CSR write in a cycle with a trap or return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | A CSR instruction is executing |
| csr_op | input | 3 | CSR operation code |
| csr_addr | input | 12 | CSR address |
| csr_src | input | XLEN | Register operand |
| csr_imm | input | 5 | Immediate operand |
| csr_rdata | output | XLEN | Old value of the addressed CSR |
| inst_pc | input | XLEN | Address of the executing instruction |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Exception code |
| exc_tval | input | XLEN | Faulting address or instruction bits |
| irq_ext | input | 1 | External interrupt pending |
| irq_sw | input | 1 | Software interrupt pending |
| irq_tim | input | 1 | Timer interrupt pending |
| next_pc | input | XLEN | Address of the next instruction not yet executed |
| sret_en | input | 1 | Supervisor return executing |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| priv_mode | output | 1 | Current mode, 1 supervisor, 0 user |

## Verification
The hardest state to reach is an interrupt taken in user mode while SIE is 0. Getting there takes an enable bit set by a CSR write, SPP cleared by an earlier return, and then a second return that drops the mode to user. All of this must happen before any CSR access or return in user mode traps back out. The random stream mixes set and write operations on the enable and status registers with frequent returns and sparse interrupt lines, so these chains form repeatedly. A reference model in the bench predicts every redirect, mode and read value along the way.

// File: rtl/s_trap_pkg.sv
package s_trap_pkg;
  localparam logic [11:0] A_STATUS = 12'h100;
  localparam logic [11:0] A_IE     = 12'h104;
  localparam logic [11:0] A_TVEC   = 12'h105;
  localparam logic [11:0] A_EPC    = 12'h141;
  localparam logic [11:0] A_CAUSE  = 12'h142;
  localparam logic [11:0] A_TVAL   = 12'h143;

  localparam int B_SIE  = 1;
  localparam int B_SPIE = 5;
  localparam int B_SPP  = 8;

  localparam int EN_SW  = 1;
  localparam int EN_TIM = 5;
  localparam int EN_EXT = 9;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_I_SW    = 1;
  localparam int CODE_I_TIM   = 5;
  localparam int CODE_I_EXT   = 9;

  localparam logic PRIV_U = 1'b0;
  localparam logic PRIV_S = 1'b1;
endpackage

// File: rtl/s_trap_irq_sel.sv
module s_trap_irq_sel #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] grant,
  output logic            any
);
  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = pend[i];
    end else begin : g_rest
      assign grant[i] = pend[i] & ~|pend[i-1:0];
    end
  end
  assign any = |pend;

  assert_grant_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ($onehot(grant) && ((grant & ~pend) == '0)));
endmodule

// File: rtl/s_trap_csr_alu.sv
module s_trap_csr_alu #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src,
  input  logic [4:0]      imm,
  output logic            wr,
  output logic [XLEN-1:0] new_val
);
  logic [XLEN-1:0] operand;
  assign operand = op[2] ? {{(XLEN-5){1'b0}}, imm} : src;

  always_comb begin
    wr = 1'b1;
    case (op[1:0])
      2'b01:   new_val = operand;
      2'b10:   new_val = old_val | operand;
      2'b11:   new_val = old_val & ~operand;
      default: begin new_val = old_val; wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/s_trap_csr.sv
module s_trap_csr
  import s_trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [2:0]        csr_op,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_src,
  input  logic [4:0]        csr_imm,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [XLEN-1:0]   inst_pc,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic              irq_ext,
  input  logic              irq_sw,
  input  logic              irq_tim,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              sret_en,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              priv_mode
);
  localparam int NSRC = 3;
  localparam logic [XLEN-1:0] IE_MASK =
    (XLEN'(1) << EN_SW) | (XLEN'(1) << EN_TIM) | (XLEN'(1) << EN_EXT);

  logic            priv_q, st_sie, st_spie, st_spp;
  logic [XLEN-1:0] ie_q, tvec_q, epc_q, cause_q, tval_q;
  logic [XLEN-1:0] status_w, new_val, cause_nxt;
  logic            alu_wr, user, take_exc, take_irq, take_trap, do_sret, do_csr, irq_on;
  logic [NSRC-1:0] pend, grant;
  logic            irq_any;
  logic [CODE_W-1:0] irq_code, exc_sel;

  assign user = (priv_q == PRIV_U);

  always_comb begin
    status_w = '0;
    status_w[B_SIE]  = st_sie;
    status_w[B_SPIE] = st_spie;
    status_w[B_SPP]  = st_spp;
  end

  always_comb begin
    case (csr_addr)
      A_STATUS: csr_rdata = status_w;
      A_IE:     csr_rdata = ie_q;
      A_TVEC:   csr_rdata = tvec_q;
      A_EPC:    csr_rdata = epc_q;
      A_CAUSE:  csr_rdata = cause_q;
      A_TVAL:   csr_rdata = tval_q;
      default:  csr_rdata = '0;
    endcase
  end

  s_trap_csr_alu #(.XLEN(XLEN)) u_alu (
    .op(csr_op), .old_val(csr_rdata), .src(csr_src), .imm(csr_imm),
    .wr(alu_wr), .new_val(new_val)
  );

  // index 0 is the highest priority source
  assign irq_on = st_sie | user;
  assign pend[0] = irq_ext & ie_q[EN_EXT] & irq_on;
  assign pend[1] = irq_sw  & ie_q[EN_SW]  & irq_on;
  assign pend[2] = irq_tim & ie_q[EN_TIM] & irq_on;

  s_trap_irq_sel #(.NSRC(NSRC)) u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant), .any(irq_any)
  );

  always_comb begin
    if (grant[0])      irq_code = CODE_W'(CODE_I_EXT);
    else if (grant[1]) irq_code = CODE_W'(CODE_I_SW);
    else               irq_code = CODE_W'(CODE_I_TIM);
  end

  assign take_exc  = exc_valid | (csr_en & user) | (sret_en & user);
  assign exc_sel   = exc_valid ? exc_code : CODE_W'(CODE_ILLEGAL);
  assign take_irq  = ~take_exc & irq_any;
  assign take_trap = take_exc | take_irq;
  assign do_sret   = sret_en & ~user & ~take_trap;
  assign do_csr    = csr_en & ~user & ~take_trap & ~do_sret & alu_wr;

  always_comb begin
    cause_nxt = '0;
    cause_nxt[CODE_W-1:0] = take_irq ? irq_code : exc_sel;
    cause_nxt[XLEN-1]     = take_irq;
  end

  assign redirect_valid = take_trap | do_sret;
  assign redirect_pc    = take_trap ? tvec_q : epc_q;
  assign priv_mode      = priv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRIV_S; st_sie <= 1'b0; st_spie <= 1'b0; st_spp <= PRIV_U;
      ie_q <= '0; tvec_q <= '0; epc_q <= '0; cause_q <= '0; tval_q <= '0;
    end else if (take_trap) begin
      cause_q <= cause_nxt;
      epc_q   <= take_irq ? next_pc : inst_pc;
      tval_q  <= exc_valid ? exc_tval : '0;
      st_spp  <= priv_q;
      priv_q  <= PRIV_S;
      st_spie <= st_sie;
      st_sie  <= 1'b0;
    end else if (do_sret) begin
      priv_q  <= st_spp;
      st_sie  <= st_spie;
      st_spie <= 1'b1;
      st_spp  <= PRIV_U;
    end else if (do_csr) begin
      case (csr_addr)
        A_STATUS: begin
          st_sie  <= new_val[B_SIE];
          st_spie <= new_val[B_SPIE];
          st_spp  <= new_val[B_SPP];
        end
        A_IE:    ie_q    <= new_val & IE_MASK;
        A_TVEC:  tvec_q  <= {new_val[XLEN-1:2], 2'b00};
        A_EPC:   epc_q   <= new_val;
        A_CAUSE: cause_q <= new_val;
        A_TVAL:  tval_q  <= new_val;
        default: ;
      endcase
    end
  end

  assert_entry_stack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (priv_q == PRIV_S && !st_sie && st_spie == $past(st_sie)
                   && st_spp == $past(priv_q)));
  assert_return_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    do_sret |=> (priv_q == $past(st_spp) && st_sie == $past(st_spie)
                 && st_spie && st_spp == PRIV_U));
  assert_user_csr_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && priv_mode == PRIV_U) |=> ($stable(tvec_q) && $stable(ie_q)
                                         && priv_mode == PRIV_S));
  assert_exc_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (!cause_q[XLEN-1] && epc_q == $past(inst_pc)));
  assert_irq_return_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !exc_valid && (irq_ext || irq_sw || irq_tim) && priv_mode == PRIV_S
     && !csr_en && !sret_en) |=> (cause_q[XLEN-1] && epc_q == $past(next_pc)));
endmodule

// File: tb/sim_s_trap_csr.sv
`timescale 1ns/1ps
module sim_s_trap_csr;
  localparam int XLEN = 32;
  localparam int NRAND = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_en, exc_valid, irq_ext, irq_sw, irq_tim, sret_en;
  logic [2:0] csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_src, inst_pc, exc_tval, next_pc, csr_rdata, redirect_pc;
  logic [4:0] csr_imm, exc_code;
  logic redirect_valid, priv_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_priv, m_sie, m_spie, m_spp;
  logic [31:0] m_ie, m_tvec, m_epc, m_cause, m_tval;

  always #2 clk = ~clk;

  s_trap_csr u0 (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_src(csr_src), .csr_imm(csr_imm), .csr_rdata(csr_rdata), .inst_pc(inst_pc),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_tval(exc_tval),
    .irq_ext(irq_ext), .irq_sw(irq_sw), .irq_tim(irq_tim), .next_pc(next_pc),
    .sret_en(sret_en), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .priv_mode(priv_mode)
  );

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      12'h100: return (32'(m_sie) << 1) | (32'(m_spie) << 5) | (32'(m_spp) << 8);
      12'h104: return m_ie;
      12'h105: return m_tvec;
      12'h141: return m_epc;
      12'h142: return m_cause;
      12'h143: return m_tval;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mnew(input logic [2:0] op, input logic [31:0] old,
                                       input logic [31:0] src, input logic [4:0] imm);
    logic [31:0] v = op[2] ? {27'h0, imm} : src;
    case (op[1:0])
      2'b01: return v;
      2'b10: return old | v;
      2'b11: return old & ~v;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    csr_en = 0; csr_op = 0; csr_addr = 0; csr_src = 0; csr_imm = 0;
    exc_valid = 0; exc_code = 0; exc_tval = 0; irq_ext = 0; irq_sw = 0; irq_tim = 0;
    sret_en = 0; inst_pc = 32'h1000; next_pc = 32'h1004;
  endtask

  // inputs are set after a negedge; check, clock, update model, return after next negedge
  task automatic cyc(input string tag);
    logic user, ill_c, ill_r, texc, ion, pe, ps, pt, tirq, trap, dsret, dcsr;
    logic [31:0] nv, ec;
    string t;
    #1;
    user = (m_priv == 1'b0);
    ill_c = csr_en && user; ill_r = sret_en && user;
    texc = exc_valid || ill_c || ill_r;
    ion = m_sie || user;
    pe = irq_ext && m_ie[9] && ion;
    ps = irq_sw && m_ie[1] && ion;
    pt = irq_tim && m_ie[5] && ion;
    tirq = !texc && (pe || ps || pt);
    trap = texc || tirq;
    dsret = sret_en && !user && !trap;
    dcsr = csr_en && !user && !trap && !dsret && (csr_op[1:0] != 2'b00);
    if (tag != "") t = tag;
    else if (exc_valid && (pe || ps || pt)) t = "R9";
    else if (exc_valid) t = "R5";
    else if (ill_c) t = "R4";
    else if (ill_r) t = "R12";
    else if (tirq && (pe + ps + pt) > 1) t = "R7";
    else if (tirq) t = "R6";
    else if (dsret) t = "R11";
    else t = "R8";
    chk(t, 32'(redirect_valid), 32'(trap || dsret));
    if (trap) chk({t, "/R10 vector"}, redirect_pc, m_tvec);
    else if (dsret) chk({t, "/R11 return pc"}, redirect_pc, m_epc);
    chk({t, " mode"}, 32'(priv_mode), 32'(m_priv));
    if (csr_en && !user)
      chk((csr_addr == 12'h100 || csr_addr == 12'h104 || csr_addr == 12'h105) ? "R3 read" : "R2 read",
          csr_rdata, mread(csr_addr));
    nv = mnew(csr_op, mread(csr_addr), csr_src, csr_imm);
    ec = exc_valid ? {27'h0, exc_code} : 32'd2;
    @(posedge clk);
    if (trap) begin
      m_cause = tirq ? (32'h8000_0000 | (pe ? 32'd9 : ps ? 32'd1 : 32'd5)) : ec;
      m_epc = tirq ? next_pc : inst_pc;
      m_tval = exc_valid ? exc_tval : 32'h0;
      m_spp = m_priv; m_priv = 1'b1; m_spie = m_sie; m_sie = 1'b0;
    end else if (dsret) begin
      m_priv = m_spp; m_sie = m_spie; m_spie = 1'b1; m_spp = 1'b0;
    end else if (dcsr) begin
      case (csr_addr)
        12'h100: begin m_sie = nv[1]; m_spie = nv[5]; m_spp = nv[8]; end
        12'h104: m_ie = nv & 32'h0000_0222;
        12'h105: m_tvec = nv & ~32'h3;
        12'h141: m_epc = nv;
        12'h142: m_cause = nv;
        12'h143: m_tval = nv;
        default: ;
      endcase
    end
    @(negedge clk);
    idle();
  endtask

  task automatic csr(input logic [2:0] op, input logic [11:0] a, input logic [31:0] s, input string tag);
    csr_en = 1; csr_op = op; csr_addr = a; csr_src = s; csr_imm = s[4:0];
    cyc(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] amap [8] = '{12'h100, 12'h104, 12'h105, 12'h141, 12'h142, 12'h143, 12'h5C0, 12'h140};
    void'($urandom(32'd7341));
    idle();
    m_priv = 1; m_sie = 0; m_spie = 0; m_spp = 0;
    m_ie = 0; m_tvec = 0; m_epc = 0; m_cause = 0; m_tval = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 redirect", 32'(redirect_valid), 32'h0);
    chk("R1 mode", 32'(priv_mode), 32'h1);
    foreach (amap[i]) csr(3'd2, amap[i], 32'h0, "R1");
    // R3: masked writes
    csr(3'd1, 12'h105, 32'hFFFF_FFFF, "R3");
    csr(3'd0, 12'h105, 32'h0, "R3");
    csr(3'd1, 12'h105, 32'h0000_8003, "R3");
    // R2: immediate forms
    csr(3'd5, 12'h143, 32'h1F, "R2");
    csr(3'd7, 12'h143, 32'h03, "R2");
    csr(3'd6, 12'h143, 32'h20, "R2");
    csr(3'd0, 12'h143, 32'h0, "R2");
    // R8: source disabled, SIE set
    csr(3'd1, 12'h104, 32'h0000_0000, "R8");
    csr(3'd2, 12'h100, 32'h0000_0002, "R8");
    irq_tim = 1; irq_ext = 1; cyc("R8");
    // R7: all pending, external first
    csr(3'd1, 12'h104, 32'hFFFF_FFFF, "R3");
    irq_tim = 1; irq_sw = 1; irq_ext = 1; next_pc = 32'h2224; cyc("R7");
    csr(3'd0, 12'h142, 32'h0, "R6");
    csr(3'd0, 12'h141, 32'h0, "R6");
    csr(3'd0, 12'h100, 32'h0, "R10");
    // R9: exception beats interrupt
    csr(3'd2, 12'h100, 32'h2, "R9");
    exc_valid = 1; exc_code = 5'd13; exc_tval = 32'hDEAD_0000; irq_sw = 1; inst_pc = 32'h3000; cyc("R9");
    csr(3'd0, 12'h142, 32'h0, "R9");
    csr(3'd0, 12'h143, 32'h0, "R5");
    // R13: CSR write discarded in a trap cycle
    csr_en = 1; csr_op = 3'd1; csr_addr = 12'h141; csr_src = 32'h5555_5555;
    exc_valid = 1; exc_code = 5'd3; inst_pc = 32'h4440; cyc("R13");
    csr(3'd0, 12'h141, 32'h0, "R13");
    // R11/R12: return to user, then illegal return and CSR access from user
    csr(3'd3, 12'h100, 32'h100, "R11");
    sret_en = 1; cyc("R11");
    sret_en = 1; inst_pc = 32'h5000; cyc("R12");
    csr(3'd0, 12'h142, 32'h0, "R12");
    sret_en = 1; cyc("R11");
    csr(3'd1, 12'h105, 32'h0, "R4");
    csr(3'd0, 12'h142, 32'h0, "R4");
    // random phase
    for (int n = 0; n < NRAND; n++) begin
      csr_en = ($urandom % 3) == 0;
      csr_op = 3'($urandom);
      csr_addr = amap[$urandom % 8];
      csr_src = ($urandom % 2) ? 32'($urandom) : (32'h222 | 32'h122);
      csr_imm = 5'($urandom);
      exc_valid = ($urandom % 10) == 0;
      exc_code = 5'($urandom);
      exc_tval = $urandom;
      irq_ext = ($urandom % 6) == 0;
      irq_sw = ($urandom % 6) == 0;
      irq_tim = ($urandom % 5) == 0;
      sret_en = ($urandom % 7) == 0;
      inst_pc = $urandom & ~32'h3;
      next_pc = inst_pc + 32'd4;
      cyc("");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule